// File: doc/BRIEF.md
# Octal DAC Register Bank with Load Strobe

This block holds the digital state behind an eight-channel, 10-bit digital-to-analog converter. A serial front end and command decoder deliver 16-bit words, each qualified by a valid strobe. The top four bits of a word carry a control code and the lower twelve bits carry data. Depending on the code, a word writes one channel's staged (input) register, presets every register to all ones, or powers up a chosen set of output buffers. All other codes are ignored.

Each channel has two registers. The staged register takes writes. The active register drives the converter. An active-low load strobe copies every staged register into its active register. While the strobe stays low, the active registers keep following the staged registers, so the bank behaves as if it were transparent. The block's outputs are the eight active codes and eight buffer power-enable bits.

Top module: `octal_dac_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every staged and active code becomes 0 and every power-enable bit becomes 0.
- R2: A valid word with control code 0000 (bits 15:12) changes no staged code, active code or power-enable bit.
- R3: A valid word with control code 2+i (0010 for channel 0 through 1001 for channel 7) loads bits 11:2 into channel i's staged register. Bits 1:0 are ignored. Other channels' staged registers are unchanged. No active code changes while `load_n_i` is high.
- R4: A valid word with control code 0001 and bit 11 set presets every staged and active code to 0x3FF at the next edge and leaves the power-enable bits unchanged. With bit 11 clear, the word is ignored.
- R5: A valid word with control code 1010 sets power-enable bit i for every i where word bit 4+i is 1. All other power-enable bits keep their value. Power-enable bits never clear except by reset.
- R6: When `load_n_i` is low at a clock edge, every active code takes the value its staged register held before that edge.
- R7: While `load_n_i` is held low, a write to a staged register reaches the matching active code one clock edge after the write edge.
- R8: Valid words with control codes 1011 through 1111 change no state.
- R9: A word presented with `word_valid_i` low changes no state, whatever its contents.
- R10: When a preset word and a low `load_n_i` coincide, the preset wins and the active codes become 0x3FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid_i | input | 1 | Qualifies `word_i` for one cycle |
| word_i | input | 16 | Control code in bits 15:12, data in bits 11:0 |
| load_n_i | input | 1 | Active-low load strobe, synchronous to `clk` |
| dac_code_o | output | 80 | Active codes; channel i at bits 10*i+9 : 10*i |
| pwr_en_o | output | 8 | Buffer power-enable per channel |

## Verification
The assertions assume that `load_n_i`, `word_valid_i` and `word_i` are already synchronous to `clk` and stable around each rising edge. Any synchronisation of the external load pin is assumed to happen upstream. They also assume reset is held for at least two edges, so that the history used by the `$past` checks is defined. The bench drives every input on the falling clock edge and holds reset for several edges before it starts.

// File: rtl/octal_dac_pkg.sv
// Package: shared control-code values and word classification for the
// octal DAC register bank. Assumes a 4-bit control field at the top of
// each interface word.
package octal_dac_pkg;

    localparam int CTRL_W      = 4;
    localparam int CTL_NOP     = 0;
    localparam int CTL_PRESET  = 1;
    localparam int CTL_WR_BASE = 2;

    typedef enum logic [1:0] {
        OP_IGNORE = 2'd0,
        OP_PRESET = 2'd1,
        OP_WRITE  = 2'd2,
        OP_POWER  = 2'd3
    } op_kind_e;

    // Sorts a control code into one of the four action kinds.
    function automatic op_kind_e classify(input logic [CTRL_W-1:0] ctl,
                                          input logic preset_bit,
                                          input int num_ch);
        int code;
        code = int'(ctl);
        if (code == CTL_NOP)
            return OP_IGNORE;
        if (code == CTL_PRESET)
            return preset_bit ? OP_PRESET : OP_IGNORE;
        if (code >= CTL_WR_BASE && code < CTL_WR_BASE + num_ch)
            return OP_WRITE;
        if (code == CTL_WR_BASE + num_ch)
            return OP_POWER;
        return OP_IGNORE;
    endfunction

endpackage

// File: rtl/octal_dac_decode.sv
// Module: octal_dac_decode
// Turns one valid-qualified interface word into per-channel write enables,
// a shared write code, a preset pulse and a power-up mask. Purely
// combinational. Assumes the control field sits in the top CTRL_W bits,
// and that the code and mask fields are left-aligned in the data field.
module octal_dac_decode
    import octal_dac_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 10,
    parameter int WORD_W = 16
) (
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              preset_o,
    output logic [NUM_CH-1:0] wr_en_o,
    output logic [CODE_W-1:0] wr_code_o,
    output logic [NUM_CH-1:0] pwr_mask_o
);
    localparam int DATA_W   = WORD_W - CTRL_W;
    localparam int CODE_LSB = DATA_W - CODE_W;
    localparam int MASK_LSB = DATA_W - NUM_CH;
    localparam int LOW_USED = (CODE_LSB < MASK_LSB) ? CODE_LSB : MASK_LSB;

    logic [CTRL_W-1:0] ctl;
    logic [DATA_W-1:0] data;
    op_kind_e          kind;

    assign ctl  = word_i[WORD_W-1 -: CTRL_W];
    assign data = word_i[DATA_W-1:0];

    // Classify the word; an unqualified word is treated as ignorable.
    always_comb begin
        kind = word_valid_i ? classify(ctl, data[DATA_W-1], NUM_CH) : OP_IGNORE;
    end

    assign preset_o   = (kind == OP_PRESET);
    assign wr_code_o  = data[DATA_W-1 -: CODE_W];
    assign pwr_mask_o = (kind == OP_POWER) ? data[DATA_W-1 -: NUM_CH] : '0;

    // One write enable per channel, matched against its own control code.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_wr
        assign wr_en_o[i] = (kind == OP_WRITE) &&
                            (ctl == CTRL_W'(CTL_WR_BASE + i));
    end

    // Data bits below every field carry no meaning.
    if (LOW_USED > 0) begin : g_low
        logic unused_low_bits;
        assign unused_low_bits = ^data[LOW_USED-1:0];
    end

endmodule

// File: rtl/octal_dac_channel.sv
// Module: octal_dac_channel
// One channel's staged and active code registers. Preset has priority over
// a write and over the load copy. The load strobe is active low, sampled
// synchronously, and copies staged to active on every edge while low.
module octal_dac_channel #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  logic              preset_i,
    input  logic              load_n_i,
    output logic [CODE_W-1:0] act_code_o
);
    logic [CODE_W-1:0] stage_q;

    // Staged register: reset, preset, or take a channel write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (preset_i)
            stage_q <= '1;
        else if (wr_en_i)
            stage_q <= wr_code_i;
    end

    // Active register: reset, preset, or copy staged while load is low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_code_o <= '0;
        else if (preset_i)
            act_code_o <= '1;
        else if (!load_n_i)
            act_code_o <= stage_q;
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (act_code_o == '0 && stage_q == '0));

    p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !preset_i) |=> $stable(stage_q));

    p_active_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_i && !preset_i) |=> $stable(act_code_o));

    p_load_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n_i && !preset_i) |=> (act_code_o == $past(stage_q)));

    p_preset_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        preset_i |=> (act_code_o == '1 && stage_q == '1));

endmodule

// File: rtl/octal_dac_power.sv
// Module: octal_dac_power
// Holds the buffer power-enable bits. A mask sets bits. Only reset clears
// them. Assumes the mask is already qualified by the decoder.
module octal_dac_power #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_mask_i,
    output logic [NUM_CH-1:0] pwr_en_o
);
    // Accumulate power-up requests.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwr_en_o <= '0;
        else
            pwr_en_o <= pwr_en_o | set_mask_i;
    end

    p_pwr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pwr_en_o & $past(pwr_en_o)) == $past(pwr_en_o)));

    p_pwr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask_i != '0) |=> ((pwr_en_o & $past(set_mask_i)) == $past(set_mask_i)));

    p_pwr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask_i == '0) |=> $stable(pwr_en_o));

endmodule

// File: rtl/octal_dac_bank.sv
// Module: octal_dac_bank (top)
// Eight double-buffered DAC code channels plus buffer power-enables,
// driven by valid-qualified interface words and an active-low load strobe.
// Assumes all inputs are synchronous to clk and that the control code
// space can hold NUM_CH write codes plus the preset and power codes.
module octal_dac_bank
    import octal_dac_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 10,
    parameter int WORD_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     word_valid_i,
    input  logic [WORD_W-1:0]        word_i,
    input  logic                     load_n_i,
    output logic [NUM_CH*CODE_W-1:0] dac_code_o,
    output logic [NUM_CH-1:0]        pwr_en_o
);
    localparam int POWER_CODE = CTL_WR_BASE + NUM_CH;

    logic              preset;
    logic [NUM_CH-1:0] wr_en;
    logic [CODE_W-1:0] wr_code;
    logic [NUM_CH-1:0] pwr_mask;

    octal_dac_decode #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W),
        .WORD_W (WORD_W)
    ) u_decode (
        .word_valid_i (word_valid_i),
        .word_i       (word_i),
        .preset_o     (preset),
        .wr_en_o      (wr_en),
        .wr_code_o    (wr_code),
        .pwr_mask_o   (pwr_mask)
    );

    // One staged/active register pair per channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        octal_dac_channel #(
            .CODE_W (CODE_W)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en_i    (wr_en[i]),
            .wr_code_i  (wr_code),
            .preset_i   (preset),
            .load_n_i   (load_n_i),
            .act_code_o (dac_code_o[i*CODE_W +: CODE_W])
        );
    end

    octal_dac_power #(
        .NUM_CH (NUM_CH)
    ) u_power (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_mask_i (pwr_mask),
        .pwr_en_o   (pwr_en_o)
    );

    p_onehot_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    p_preset_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        preset |-> (wr_en == '0 && pwr_mask == '0));

    p_invalid_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_i |-> (!preset && wr_en == '0 && pwr_mask == '0));

    p_undef_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_i && int'(word_i[WORD_W-1 -: CTRL_W]) > POWER_CODE)
        |-> (!preset && wr_en == '0 && pwr_mask == '0));

    p_nop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_i && int'(word_i[WORD_W-1 -: CTRL_W]) == CTL_NOP)
        |-> (!preset && wr_en == '0 && pwr_mask == '0));

endmodule

// File: tb/octal_dac_bank_tb.sv
// Bench for octal_dac_bank: a vector table walked by one loop, then
// directed tests for load tracking, preset priority, per-channel writes
// and reset.
module octal_dac_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word = 16'h0;
    logic        load_n = 1'b1;
    logic [79:0] dac_code;
    logic [7:0]  pwr_en;

    int n_checks = 0;
    int n_bad    = 0;
    logic [9:0] exp_code [8];

    always #4 clk = ~clk;

    octal_dac_bank u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_valid_i (word_valid),
        .word_i       (word),
        .load_n_i     (load_n),
        .dac_code_o   (dac_code),
        .pwr_en_o     (pwr_en)
    );

    typedef struct packed {
        logic        v;
        logic [15:0] w;
        logic        l;
        logic [2:0]  ch;
        logic [9:0]  code;
        logic [7:0]  pwr;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b1, 16'h2554, 1'b1, 3'd0, 10'h000, 8'h00, 4'd3},  // R3 write ch0, active held
        '{1'b0, 16'h0000, 1'b0, 3'd0, 10'h155, 8'h00, 4'd6},  // R6 load copies ch0
        '{1'b1, 16'h9E80, 1'b1, 3'd7, 10'h000, 8'h00, 4'd3},  // R3 write ch7
        '{1'b1, 16'h0FFF, 1'b0, 3'd7, 10'h3A0, 8'h00, 4'd2},  // R2 nop with load
        '{1'b1, 16'hA850, 1'b1, 3'd0, 10'h155, 8'h85, 4'd5},  // R5 power mask
        '{1'b1, 16'hA020, 1'b1, 3'd7, 10'h3A0, 8'h87, 4'd5},  // R5 more bits kept
        '{1'b1, 16'hB3FF, 1'b0, 3'd0, 10'h155, 8'h87, 4'd8},  // R8 undefined code
        '{1'b0, 16'h2FFC, 1'b0, 3'd0, 10'h155, 8'h87, 4'd9},  // R9 unqualified word
        '{1'b1, 16'h1000, 1'b0, 3'd0, 10'h155, 8'h87, 4'd4},  // R4 preset bit clear
        '{1'b1, 16'h1800, 1'b1, 3'd3, 10'h3FF, 8'h87, 4'd4}   // R4 preset all ones
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge, return at the next one.
    task automatic apply(input logic v, input logic [15:0] w, input logic l);
        word_valid = v;
        word       = w;
        load_n     = l;
        @(negedge clk);
    endtask

    function automatic logic [9:0] chan(input int ch);
        return dac_code[ch*10 +: 10];
    endfunction

    function automatic logic [15:0] wr_word(input int ch, input logic [9:0] code);
        return {4'(ch + 2), code, 2'b00};
    endfunction

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int c = 0; c < 8; c++) check("R1 reset code", 32'(chan(c)), 32'h0);
        check("R1 reset power", 32'(pwr_en), 32'h0);
        rst_n = 1'b1;

        for (int k = 0; k < 10; k++) begin
            apply(VECS[k].v, VECS[k].w, VECS[k].l);
            check($sformatf("R%0d vec%0d code", VECS[k].req, k),
                  32'(chan(int'(VECS[k].ch))), 32'(VECS[k].code));
            check($sformatf("R%0d vec%0d power", VECS[k].req, k),
                  32'(pwr_en), 32'(VECS[k].pwr));
        end

        // R7: load held low, active follows staged one edge later
        apply(1'b1, wr_word(2, 10'h0AB), 1'b0);
        check("R7 same edge old", 32'(chan(2)), 32'h3FF);
        apply(1'b0, 16'h0, 1'b0);
        check("R7 next edge new", 32'(chan(2)), 32'h0AB);
        apply(1'b1, wr_word(2, 10'h200), 1'b0);
        check("R7 second write lag", 32'(chan(2)), 32'h0AB);
        apply(1'b0, 16'h0, 1'b0);
        check("R7 second write seen", 32'(chan(2)), 32'h200);

        // R10: preset with load low beats the staged write
        apply(1'b1, wr_word(1, 10'h123), 1'b1);
        apply(1'b1, 16'h1800, 1'b0);
        check("R10 preset over load", 32'(chan(1)), 32'h3FF);
        check("R4 preset keeps power", 32'(pwr_en), 32'h87);

        // R3: distinct value per channel, then a single-channel update
        for (int c = 0; c < 8; c++) begin
            exp_code[c] = 10'((c * 71 + 9) & 32'h3FF);
            apply(1'b1, wr_word(c, exp_code[c]), 1'b1);
        end
        for (int c = 0; c < 8; c++) check("R3 held before load", 32'(chan(c)), 32'h3FF);
        apply(1'b0, 16'h0, 1'b0);
        for (int c = 0; c < 8; c++) check("R3 per channel", 32'(chan(c)), 32'(exp_code[c]));
        exp_code[5] = 10'h0F0;
        apply(1'b1, wr_word(5, 10'h0F0), 1'b1);
        apply(1'b0, 16'h0, 1'b0);
        for (int c = 0; c < 8; c++) check("R3 others unchanged", 32'(chan(c)), 32'(exp_code[c]));

        // R1: reset mid-run
        rst_n = 1'b0;
        apply(1'b0, 16'h0, 1'b1);
        apply(1'b0, 16'h0, 1'b1);
        for (int c = 0; c < 8; c++) check("R1 mid-run reset", 32'(chan(c)), 32'h0);
        check("R1 mid-run power", 32'(pwr_en), 32'h0);
        rst_n = 1'b1;

        // R5: full mask after reset
        apply(1'b1, 16'hAFF0, 1'b1);
        check("R5 full mask", 32'(pwr_en), 32'hFF);

        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule